// File: doc/BRIEF.md
# Four-Tap Weighted Window Loop Engine

This block runs a fixed loop over a source array `b` and fills a destination array `a`. Each element is `a[i] = 11*b[i] + 22*b[i+1] + 33*b[i+2] + 44*b[i+3]`. The index `i` runs from 0 while it is below a trip count that is latched at start. The datapath has a fixed set of resources: four multipliers, two adders and one magnitude comparator. Each loop pass follows a four-cycle schedule with no overlap between passes. Address generation is plain wiring and uses none of these resources.

A host pulses `start` together with a trip count. The engine then issues one wide read per pass, receiving four consecutive 16-bit elements one cycle later. It issues one write per pass and finally pulses `done`. The source memory is assumed to be a synchronous array that returns data in the cycle after the read. The destination memory takes the write on the edge that closes the write cycle.

Top module: `tap4_loop_accel`

## Requirements
- R1: Each written value equals 11*b[i] + 22*b[i+1] + 33*b[i+2] + 44*b[i+3]. Here b[i+k] is read from bits [16k+15:16k] of `src_data`, and the write goes to destination index i.
- R2: A pass asserts `src_rd` in its first cycle and `dst_wr` in its fourth cycle. Counting from the clock edge that accepts start, the write of element i is presented in cycle 4i+4, and no two writes are less than four cycles apart.
- R3: The result is 24 bits wide and never wraps. All-0xFFFF inputs give 7208850.
- R4: The indexes 0..N-1 are each written exactly once and in ascending order. `src_addr` and `dst_addr` both carry i, and no destination index at or above N is written.
- R5: `busy` is high from the cycle after start until the cycle of `done` inclusive. `done` is high for exactly one cycle, in cycle 4N+1, right after the last write.
- R6: A trip count of 0 performs no read and no write, and pulses `done` in cycle 1.
- R7: A `start` raised while `busy` is high has no effect on the running loop.
- R8: An active-low asynchronous reset returns the engine to idle at once. `busy`, `done`, `src_rd` and `dst_wr` drop without waiting for a clock edge.
- R9: The trip count is sampled only when start is accepted. Later changes on `trip_count` do not change the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, taken only when idle |
| trip_count | input | CNT_W | Number of elements to produce |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| src_rd | output | 1 | Read request for four source elements |
| src_addr | output | CNT_W | Index of the first of the four elements |
| src_data | input | 4*DATA_W | Four source elements, lane k holds b[i+k] |
| dst_wr | output | 1 | Destination write strobe |
| dst_addr | output | CNT_W | Destination index |
| dst_data | output | ACC_W | Weighted sum |

## Verification
The bench builds the engine with an 8-bit trip count and keeps the 16-bit data and 24-bit result widths. With these values the full trip-count range, up to 255, runs in about a thousand cycles. The bench therefore sweeps short counts, zero and the maximum count under ramp, pseudo-random, zero and all-ones data. The all-ones data brings the overflow boundary within reach. Mid-run start pulses, trip-count changes and an asynchronous reset in the middle of a loop are also exercised.

// File: rtl/tap4_pkg.sv
package tap4_pkg;

  localparam int TAPS = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MUL   = 3'd2,
    ST_SUM   = 3'd3,
    ST_WRITE = 3'd4,
    ST_FIN   = 3'd5
  } phase_t;

  // Weight of tap k: base * (k + 1), giving 11, 22, 33, 44 for base 11.
  function automatic int unsigned tap_weight(input int unsigned base, input int unsigned k);
    return base * (k + 1);
  endfunction

endpackage

// File: rtl/tap4_ctrl.sv
module tap4_ctrl
  import tap4_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] trip_count,
  output logic [CNT_W-1:0] idx,
  output logic             busy,
  output logic             done,
  output logic             rd_en,
  output logic             mul_en,
  output logic             sum_en,
  output logic             wr_en
);

  localparam int CMP_W = CNT_W + 1;

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] idx_q;
  logic [CMP_W-1:0] cmp_a, cmp_b;
  logic             go_on;
  logic             accept;

  assign accept = start && (phase_q == ST_IDLE);

  // Single loop comparator, operands chosen by phase.
  always_comb begin
    if (phase_q == ST_IDLE) begin
      cmp_a = '0;
      cmp_b = {1'b0, trip_count};
    end else begin
      cmp_a = {1'b0, idx_q} + CMP_W'(1);
      cmp_b = {1'b0, limit_q};
    end
  end
  assign go_on = cmp_a < cmp_b;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_IDLE:  if (accept) phase_d = go_on ? ST_READ : ST_FIN;
      ST_READ:  phase_d = ST_MUL;
      ST_MUL:   phase_d = ST_SUM;
      ST_SUM:   phase_d = ST_WRITE;
      ST_WRITE: phase_d = go_on ? ST_READ : ST_FIN;
      ST_FIN:   phase_d = ST_IDLE;
      default:  phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      limit_q <= '0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        limit_q <= trip_count;
        idx_q   <= '0;
      end else if (phase_q == ST_WRITE && go_on) begin
        idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  assign idx    = idx_q;
  assign busy   = (phase_q != ST_IDLE);
  assign done   = (phase_q == ST_FIN);
  assign rd_en  = (phase_q == ST_READ);
  assign mul_en = (phase_q == ST_MUL);
  assign sum_en = (phase_q == ST_SUM);
  assign wr_en  = (phase_q == ST_WRITE);

  // R7: a start while running leaves the latched count and the index alone
  a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(limit_q) && (phase_q != ST_READ || $past(phase_q) == ST_WRITE)));

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: a read is only issued for an index below the count
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ({1'b0, idx_q} < {1'b0, limit_q}));

  // R2: reads never repeat in back-to-back cycles
  a_r2_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

endmodule

// File: rtl/tap4_mul_stage.sv
module tap4_mul_stage
  import tap4_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 24,
  parameter int COEF_BASE = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [TAPS*DATA_W-1:0]       lanes,
  output logic [TAPS-1:0][ACC_W-1:0]   prod
);

  logic [TAPS-1:0][ACC_W-1:0] prod_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    localparam int unsigned WEIGHT = tap_weight(COEF_BASE, k);
    logic [DATA_W-1:0] lane;
    assign lane = lanes[k*DATA_W +: DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[k] <= '0;
      else if (en) prod_q[k] <= ACC_W'(lane) * ACC_W'(WEIGHT);
    end
  end

  assign prod = prod_q;

endmodule

// File: rtl/tap4_add_tree.sv
module tap4_add_tree
  import tap4_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sum_en,
  input  logic                       final_sel,
  input  logic [TAPS-1:0][ACC_W-1:0] prod,
  output logic [ACC_W-1:0]           total
);

  logic [ACC_W-1:0] pair_lo_q, pair_hi_q;
  logic [ACC_W-1:0] add_a_x, add_a_y, add_a_out;
  logic [ACC_W-1:0] add_b_out;

  // Adder A is shared: first partial sum, then the final sum.
  assign add_a_x   = final_sel ? pair_lo_q : prod[0];
  assign add_a_y   = final_sel ? pair_hi_q : prod[1];
  assign add_a_out = add_a_x + add_a_y;
  // Adder B: second partial sum.
  assign add_b_out = prod[2] + prod[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_lo_q <= '0;
      pair_hi_q <= '0;
    end else if (sum_en) begin
      pair_lo_q <= add_a_out;
      pair_hi_q <= add_b_out;
    end
  end

  assign total = add_a_out;

  // R3: the final sum never wraps below either partial sum
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    final_sel |-> (total >= pair_lo_q && total >= pair_hi_q));

endmodule

// File: rtl/tap4_loop_accel.sv
module tap4_loop_accel
  import tap4_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 20,
  parameter int ACC_W     = 24,
  parameter int COEF_BASE = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       trip_count,
  output logic                   busy,
  output logic                   done,
  output logic                   src_rd,
  output logic [CNT_W-1:0]       src_addr,
  input  logic [4*DATA_W-1:0]    src_data,
  output logic                   dst_wr,
  output logic [CNT_W-1:0]       dst_addr,
  output logic [ACC_W-1:0]       dst_data
);

  logic [CNT_W-1:0]           idx;
  logic                       mul_en, sum_en, wr_en, rd_en;
  logic [TAPS-1:0][ACC_W-1:0] prod;
  logic [ACC_W-1:0]           total;

  tap4_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .trip_count(trip_count),
    .idx(idx), .busy(busy), .done(done), .rd_en(rd_en),
    .mul_en(mul_en), .sum_en(sum_en), .wr_en(wr_en)
  );

  tap4_mul_stage #(.DATA_W(DATA_W), .ACC_W(ACC_W), .COEF_BASE(COEF_BASE)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(mul_en), .lanes(src_data), .prod(prod)
  );

  tap4_add_tree #(.ACC_W(ACC_W)) u_add (
    .clk(clk), .rst_n(rst_n), .sum_en(sum_en), .final_sel(wr_en),
    .prod(prod), .total(total)
  );

  assign src_rd   = rd_en;
  assign src_addr = idx;
  assign dst_wr   = wr_en;
  assign dst_addr = idx;
  assign dst_data = total;

  // R2: every write follows its read by exactly three cycles
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr |-> $past(src_rd, 3));

  // R5/R6: done comes right after a write or right after an idle start
  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dst_wr) || !$past(busy)));

  // R4: write index equals the index that was read
  a_r4_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr |-> (dst_addr == $past(src_addr, 3)));

endmodule

// File: tb/tb_tap4_loop_accel.sv
`timescale 1ns/1ps
module tb_tap4_loop_accel;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int ACC_W  = 24;
  localparam int MEM_D  = (1 << CNT_W) + 4;
  localparam logic [ACC_W-1:0] SENT = 24'hABCDEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] trip_count = '0;
  logic busy, done, src_rd, dst_wr;
  logic [CNT_W-1:0] src_addr, dst_addr;
  logic [4*DATA_W-1:0] src_data;
  logic [ACC_W-1:0] dst_data;

  logic [DATA_W-1:0] bmem [MEM_D];
  logic [ACC_W-1:0]  amem [MEM_D];

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tap4_loop_accel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .COEF_BASE(11)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .trip_count(trip_count),
    .busy(busy), .done(done), .src_rd(src_rd), .src_addr(src_addr),
    .src_data(src_data), .dst_wr(dst_wr), .dst_addr(dst_addr), .dst_data(dst_data)
  );

  // Synchronous source memory: data one cycle after the read.
  always @(posedge clk) begin
    if (src_rd)
      src_data <= {bmem[int'(src_addr)+3], bmem[int'(src_addr)+2],
                   bmem[int'(src_addr)+1], bmem[int'(src_addr)]};
  end

  always @(posedge clk) begin
    if (dst_wr) amem[dst_addr] <= dst_data;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_at(input int i);
    // 11*(b0 + 2*b1 + 3*b2 + 4*b3)
    return 11 * (int'(bmem[i]) + 2*int'(bmem[i+1]) + 3*int'(bmem[i+2]) + 4*int'(bmem[i+3]));
  endfunction

  task automatic fill(input int pat);
    for (int j = 0; j < MEM_D; j++) begin
      case (pat)
        0: bmem[j] = DATA_W'(j * 257);
        1: bmem[j] = '1;
        2: bmem[j] = DATA_W'(j * 40503 + 12345);
        default: bmem[j] = (j % 3 == 0) ? 16'h8001 : 16'h0000;
      endcase
      amem[j] = SENT;
    end
  endtask

  // Runs one loop of n elements; inject=1 pulses start and changes the count mid-run.
  task automatic run(input int n, input bit inject);
    int k;
    int widx;
    bit fin;
    @(negedge clk);
    trip_count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    trip_count = CNT_W'(n) ^ 8'h5A;   // R9: change after acceptance
    k = 1;
    widx = 0;
    fin = 1'b0;
    while (!fin) begin
      if (k == 1) chk(busy == 1'b1, "R5 busy after start", busy, 1);
      if (inject && k == 2) start = 1'b1;       // R7
      if (inject && k == 3) start = 1'b0;
      if (dst_wr) begin
        chk(int'(dst_addr) == widx, "R4 write index", dst_addr, widx);
        chk(k == 4*widx + 4, "R2 write cycle", k, 4*widx + 4);
        chk(int'(dst_data) == expect_at(widx), "R1/R3 result", dst_data, expect_at(widx));
        widx++;
      end
      if (done) begin
        chk(k == 4*n + 1, n == 0 ? "R6 done cycle" : "R5 done cycle", k, 4*n + 1);
        chk(widx == n, "R4/R9 write count", widx, n);
        fin = 1'b1;
      end else if (k > 4*n + 20) begin
        chk(1'b0, "R5 done never seen", k, 4*n + 1);
        fin = 1'b1;
      end
      if (!fin) begin
        @(negedge clk);
        k++;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R5 done single pulse", done, 0);
    chk(busy == 1'b0, "R5 idle after done", busy, 0);
    chk(amem[n] == SENT, "R4 no write past count", amem[n], SENT);
    if (n > 0) chk(int'(amem[n-1]) == expect_at(n-1), "R1 stored last", amem[n-1], expect_at(n-1));
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill(0);
    #1;
    chk(busy == 1'b0 && done == 1'b0 && src_rd == 1'b0 && dst_wr == 1'b0,
        "R8 reset state", {busy, done, src_rd, dst_wr}, 0);
    #22;
    rst_n = 1'b1;

    for (int pat = 0; pat < 4; pat++) begin
      fill(pat);
      run(0, 1'b0);
      run(1, 1'b0);
      run(2, 1'b0);
      run(3, 1'b1);
      run(5, 1'b0);
      run(9, 1'b1);
    end

    // R3: all-ones data at the top of the range
    fill(1);
    run(255, 1'b0);
    chk(int'(amem[0]) == 7208850, "R3 max value", amem[0], 7208850);
    fill(2);
    run(255, 1'b1);

    // R8: asynchronous reset in the middle of a run
    fill(0);
    @(negedge clk);
    trip_count = 8'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    chk(dst_wr == 1'b0 && src_rd == 1'b0 && done == 1'b0, "R8 strobes cleared",
        {dst_wr, src_rd, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    fill(3);
    run(4, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule